// File: doc/BRIEF.md
# Exception Entry and Mode Controller

This block decides when a processor core leaves its normal instruction flow for an exception handler, and what that switch writes. It watches seven request lines (reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt, fast interrupt) together with the live status word. When one or more requests are eligible, it picks the most urgent one and computes the handler's mode and vector address. It then drives a single-cycle set of write strobes with their values: the return address into the link register of the new mode's bank, the old status word into that bank's saved status register, a new status word, and a new program counter.

A second path leaves a handler. On a return request it writes the saved status word back into the live status word and the return address into the program counter in the same cycle. This means the core never sees a state where the mode has switched but the jump has not happened, or the other way round. The register storage, instruction decode and pipeline flush sit outside this block. It only emits strobes and the values that go with them. Every output is registered: a request sampled at one rising edge shows up on the outputs just after that edge and holds for exactly one cycle. There is no streaming data at its edge, so all pins are plain control and value signals.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The program counter written on entry is the handler vector: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R2: `entry_mode` gives the 5-bit mode of the handler: supervisor 5'b10011 for reset and software interrupt, abort 5'b10111 for both aborts, undefined 5'b11011, normal interrupt 5'b10010, fast interrupt 5'b10001.
- R3: When several requests are eligible together, exactly one is taken. The order from most to least urgent is: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R4: A normal interrupt request is ignored while status bit 7 is 1. A fast interrupt request is ignored while status bit 6 is 1.
- R5: On every entry except reset, `lr_we` is 1 and `lr_data` equals the `next_pc` sampled with the request. On reset, `lr_we` is 0.
- R6: On every entry except reset, `spsr_we` is 1 and `spsr_data` equals the `cur_status` sampled with the request. On reset, `spsr_we` is 0.
- R7: On entry, the new status word (`cpsr_data`, with `cpsr_we`=1) keeps bits [31:8] of the old word. Bit 7 is set to 1. Bit 6 is set to 1 on fast interrupt and reset entry and is kept otherwise. Bit 5 (the compressed-instruction state flag) is cleared. Bits [4:0] hold the new mode.
- R8: Requests other than reset are taken only in a cycle where `insn_done` is 1. Reset is taken in any cycle.
- R9: A return (`ret_req` and `insn_done`, with no exception taken that cycle) raises `ret_stb`, `cpsr_we` and `pc_we` in the same cycle, with `cpsr_data`=`saved_status` and `pc_data`=`ret_addr`. It leaves `lr_we` and `spsr_we` at 0. An exception taken in the same cycle wins over the return.
- R10: All strobes are 0 after `rst_n` goes low. A request sampled at a rising edge drives the outputs after that edge for that cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| req_reset | input | 1 | Core reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| insn_done | input | 1 | Current instruction completes this cycle |
| cur_status | input | 32 | Live status word |
| next_pc | input | 32 | Address of the following instruction |
| ret_req | input | 1 | Leave the handler |
| saved_status | input | 32 | Saved status word of the current mode |
| ret_addr | input | 32 | Return address for the handler exit |
| entry_stb | output | 1 | An exception was entered |
| ret_stb | output | 1 | A handler return was performed |
| entry_mode | output | 5 | Mode of the entered handler; selects the banked registers |
| pc_we | output | 1 | Program counter write strobe |
| pc_data | output | 32 | New program counter |
| lr_we | output | 1 | Link register write strobe for the `entry_mode` bank |
| lr_data | output | 32 | Return address to store |
| spsr_we | output | 1 | Saved status write strobe for the `entry_mode` bank |
| spsr_data | output | 32 | Status word to save |
| cpsr_we | output | 1 | Live status word write strobe |
| cpsr_data | output | 32 | New live status word |

## Verification
The bench targets the mask bits. With bit 7 set, a design that checks the wrong bit would take a normal interrupt, or let it shadow a lower-priority prefetch abort. The bench pairs requests across the priority order, so a swapped pair shows up as the wrong vector and mode. It also checks that reset writes neither the link register nor the saved status, that the compressed-state flag is cleared while the upper flags are kept, and that an exception firing together with a return suppresses the return. A design that sets the two status writes in different cycles, or lets a return through without `insn_done`, is caught by the return cases.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STATUS_W = 32;
  localparam int MODE_W   = 5;
  localparam int NUM_KINDS = 7;
  localparam int KIND_W = $clog2(NUM_KINDS);

  // index order is priority order, 0 most urgent
  typedef enum logic [KIND_W-1:0] {
    EK_RESET = 3'd0,
    EK_DABT  = 3'd1,
    EK_FIQ   = 3'd2,
    EK_IRQ   = 3'd3,
    EK_PABT  = 3'd4,
    EK_UNDEF = 3'd5,
    EK_SWI   = 3'd6
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam int BIT_IMASK = 7;
  localparam int BIT_FMASK = 6;
  localparam int BIT_TSTATE = 5;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N-1:0] seen;  // seen[i]: some req at index below i

  assign seen[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_seen
      assign seen[gi] = seen[gi-1] | req[gi-1];
    end
    for (gi = 0; gi < N; gi++) begin : g_grant
      assign grant[gi] = req[gi] & ~seen[gi];
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/exc_target_map.sv
module exc_target_map
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  exc_kind_e           kind,
  output logic [MODE_W-1:0]   mode,
  output logic [ADDR_W-1:0]   vector
);
  logic [4:0] slot;  // vector word index

  always_comb begin
    case (kind)
      EK_RESET: begin mode = MODE_SVC; slot = 5'd0; end
      EK_UNDEF: begin mode = MODE_UND; slot = 5'd1; end
      EK_SWI:   begin mode = MODE_SVC; slot = 5'd2; end
      EK_PABT:  begin mode = MODE_ABT; slot = 5'd3; end
      EK_DABT:  begin mode = MODE_ABT; slot = 5'd4; end
      EK_IRQ:   begin mode = MODE_IRQ; slot = 5'd6; end
      EK_FIQ:   begin mode = MODE_FIQ; slot = 5'd7; end
      default:  begin mode = MODE_SVC; slot = 5'd0; end
    endcase
  end

  assign vector = VEC_BASE + ADDR_W'({slot, 2'b00});
endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen
  import exc_pkg::*;
(
  input  logic [STATUS_W-1:0] old_status,
  input  exc_kind_e           kind,
  input  logic [MODE_W-1:0]   mode,
  output logic [STATUS_W-1:0] new_status
);
  logic fmask_force;
  assign fmask_force = (kind == EK_FIQ) || (kind == EK_RESET);

  always_comb begin
    new_status = old_status;
    new_status[BIT_IMASK]  = 1'b1;
    new_status[BIT_FMASK]  = old_status[BIT_FMASK] | fmask_force;
    new_status[BIT_TSTATE] = 1'b0;
    new_status[MODE_W-1:0] = mode;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_reset,
  input  logic                req_undef,
  input  logic                req_swi,
  input  logic                req_pabt,
  input  logic                req_dabt,
  input  logic                req_irq,
  input  logic                req_fiq,
  input  logic                insn_done,
  input  logic [STATUS_W-1:0] cur_status,
  input  logic [ADDR_W-1:0]   next_pc,
  input  logic                ret_req,
  input  logic [STATUS_W-1:0] saved_status,
  input  logic [ADDR_W-1:0]   ret_addr,
  output logic                entry_stb,
  output logic                ret_stb,
  output logic [MODE_W-1:0]   entry_mode,
  output logic                pc_we,
  output logic [ADDR_W-1:0]   pc_data,
  output logic                lr_we,
  output logic [ADDR_W-1:0]   lr_data,
  output logic                spsr_we,
  output logic [STATUS_W-1:0] spsr_data,
  output logic                cpsr_we,
  output logic [STATUS_W-1:0] cpsr_data
);
  logic [NUM_KINDS-1:0] elig;
  logic [NUM_KINDS-1:0] grant;
  logic [KIND_W-1:0]    win_idx;
  logic                 take;
  exc_kind_e            win_kind;
  logic [MODE_W-1:0]    win_mode;
  logic [ADDR_W-1:0]    win_vec;
  logic [STATUS_W-1:0]  win_status;
  logic                 ret_go;

  // eligibility: reset ignores instruction boundary and masks
  assign elig[EK_RESET] = req_reset;
  assign elig[EK_DABT]  = req_dabt  & insn_done;
  assign elig[EK_FIQ]   = req_fiq   & insn_done & ~cur_status[BIT_FMASK];
  assign elig[EK_IRQ]   = req_irq   & insn_done & ~cur_status[BIT_IMASK];
  assign elig[EK_PABT]  = req_pabt  & insn_done;
  assign elig[EK_UNDEF] = req_undef & insn_done;
  assign elig[EK_SWI]   = req_swi   & insn_done;

  exc_prio_pick #(.N(NUM_KINDS)) u_pick (
    .req(elig), .grant(grant), .idx(win_idx), .any(take)
  );

  assign win_kind = exc_kind_e'(win_idx);

  exc_target_map #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_map (
    .kind(win_kind), .mode(win_mode), .vector(win_vec)
  );

  exc_status_gen u_stat (
    .old_status(cur_status), .kind(win_kind), .mode(win_mode),
    .new_status(win_status)
  );

  assign ret_go = ret_req & insn_done & ~take;

  // R3: a single winner at most
  always_comb begin
    assert_one_winner_R3: assert ($onehot0(grant));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_stb  <= 1'b0;
      ret_stb    <= 1'b0;
      entry_mode <= MODE_SVC;
      pc_we      <= 1'b0;
      pc_data    <= '0;
      lr_we      <= 1'b0;
      lr_data    <= '0;
      spsr_we    <= 1'b0;
      spsr_data  <= '0;
      cpsr_we    <= 1'b0;
      cpsr_data  <= '0;
    end else begin
      entry_stb  <= take;
      ret_stb    <= ret_go;
      entry_mode <= win_mode;
      pc_we      <= take | ret_go;
      pc_data    <= take ? win_vec : ret_addr;
      lr_we      <= take & ~grant[EK_RESET];
      lr_data    <= next_pc;
      spsr_we    <= take & ~grant[EK_RESET];
      spsr_data  <= cur_status;
      cpsr_we    <= take | ret_go;
      cpsr_data  <= take ? win_status : saved_status;
    end
  end

  // R4: interrupt entries only when unmasked at sampling time
  assert_irq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && entry_mode == MODE_IRQ) |-> !$past(cur_status[BIT_IMASK]));
  assert_fiq_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && entry_mode == MODE_FIQ) |-> !$past(cur_status[BIT_FMASK]));

  // R8: only reset may enter mid-instruction
  assert_wait_insn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && !$past(req_reset)) |-> $past(insn_done));

  // R5: link value is the sampled following address
  assert_link_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> (entry_stb && lr_data == $past(next_pc)));

  // R6: saved status is the sampled live word
  assert_saved_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (entry_stb && spsr_data == $past(cur_status)));

  // R7: entry status word shape
  assert_entry_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_stb |-> (cpsr_we && cpsr_data[BIT_IMASK] && !cpsr_data[BIT_TSTATE]
                   && cpsr_data[MODE_W-1:0] == entry_mode));

  // R9: return and entry never in the same cycle; return writes both together
  assert_ret_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_stb, ret_stb}));
  assert_ret_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_stb |-> (pc_we && cpsr_we && !lr_we && !spsr_we));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
  logic req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic insn_done = 0, ret_req = 0;
  logic [31:0] cur_status = '0, next_pc = '0, saved_status = '0, ret_addr = '0;
  logic entry_stb, ret_stb, pc_we, lr_we, spsr_we, cpsr_we;
  logic [4:0] entry_mode;
  logic [31:0] pc_data, lr_data, spsr_data, cpsr_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq),
    .req_fiq(req_fiq), .insn_done(insn_done), .cur_status(cur_status),
    .next_pc(next_pc), .ret_req(ret_req), .saved_status(saved_status),
    .ret_addr(ret_addr), .entry_stb(entry_stb), .ret_stb(ret_stb),
    .entry_mode(entry_mode), .pc_we(pc_we), .pc_data(pc_data),
    .lr_we(lr_we), .lr_data(lr_data), .spsr_we(spsr_we),
    .spsr_data(spsr_data), .cpsr_we(cpsr_we), .cpsr_data(cpsr_data)
  );

  // kind codes used by the bench: 0 reset,1 dabt,2 fiq,3 irq,4 pabt,5 undef,6 swi
  function automatic logic [31:0] exp_vec(int k);
    case (k)
      0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
      4: return 32'h0C; 5: return 32'h04; default: return 32'h08;
    endcase
  endfunction
  function automatic logic [4:0] exp_mode(int k);
    case (k)
      0: return 5'b10011; 1: return 5'b10111; 2: return 5'b10001;
      3: return 5'b10010; 4: return 5'b10111; 5: return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction
  function automatic logic [31:0] exp_status(int k, logic [31:0] c);
    logic [31:0] s;
    s = c;
    s[7] = 1'b1;
    if (k == 0 || k == 2) s[6] = 1'b1;
    s[5] = 1'b0;
    s[4:0] = exp_mode(k);
    return s;
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic set_req(int k, logic v);
    case (k)
      0: req_reset = v; 1: req_dabt = v; 2: req_fiq = v; 3: req_irq = v;
      4: req_pabt = v; 5: req_undef = v; default: req_swi = v;
    endcase
  endtask

  task automatic clear_in();
    for (int k = 0; k < 7; k++) set_req(k, 1'b0);
    ret_req = 0;
    insn_done = 0;
  endtask

  // inputs set before call (after a negedge); sample just after next posedge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_in();
    step();
    @(negedge clk);
  endtask

  task automatic check_entry(string tag, int k, logic [31:0] c, logic [31:0] npc);
    chk({tag, " entry_stb"}, 32'(entry_stb), 32'd1);
    chk({tag, " R1 vector"}, pc_data, exp_vec(k));
    chk({tag, " R1 pc_we"}, 32'(pc_we), 32'd1);
    chk({tag, " R2 mode"}, 32'(entry_mode), 32'(exp_mode(k)));
    chk({tag, " R7 status"}, cpsr_data, exp_status(k, c));
    if (k == 0) begin
      chk({tag, " R5 no link write on reset"}, 32'(lr_we), 32'd0);
      chk({tag, " R6 no save on reset"}, 32'(spsr_we), 32'd0);
    end else begin
      chk({tag, " R5 link"}, lr_data, npc);
      chk({tag, " R5 lr_we"}, 32'(lr_we), 32'd1);
      chk({tag, " R6 saved"}, spsr_data, c);
      chk({tag, " R6 spsr_we"}, 32'(spsr_we), 32'd1);
    end
    chk({tag, " R9 no return"}, 32'(ret_stb), 32'd0);
  endtask

  task automatic t_reset_state();
    chk("R10 reset entry_stb", 32'(entry_stb), 0);
    chk("R10 reset pc_we", 32'(pc_we), 0);
    chk("R10 reset lr_we", 32'(lr_we), 0);
    chk("R10 reset spsr_we", 32'(spsr_we), 0);
    chk("R10 reset cpsr_we", 32'(cpsr_we), 0);
    chk("R10 reset ret_stb", 32'(ret_stb), 0);
  endtask

  task automatic t_each_kind(logic [31:0] c);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      clear_in();
      set_req(k, 1'b1);
      insn_done = 1;
      cur_status = c;
      next_pc = 32'h1000 + 32'(k * 4);
      step();
      check_entry("R1 R2 single", k, c, 32'h1000 + 32'(k * 4));
      idle();
    end
  endtask

  task automatic t_pair(int hi, int lo);
    @(negedge clk);
    clear_in();
    set_req(hi, 1'b1);
    set_req(lo, 1'b1);
    insn_done = 1;
    cur_status = 32'h2000_0010;
    next_pc = 32'h4444;
    step();
    check_entry("R3 priority", hi, 32'h2000_0010, 32'h4444);
    idle();
  endtask

  task automatic t_masks();
    // irq masked by bit 7: lower prefetch abort wins
    @(negedge clk);
    clear_in();
    req_irq = 1; req_pabt = 1; insn_done = 1;
    cur_status = 32'h0000_0090; next_pc = 32'h50;
    step();
    check_entry("R4 irq masked", 4, 32'h0000_0090, 32'h50);
    idle();
    // fiq masked by bit 6: irq taken
    clear_in();
    req_fiq = 1; req_irq = 1; insn_done = 1;
    cur_status = 32'h0000_0050; next_pc = 32'h60;
    step();
    check_entry("R4 fiq masked", 3, 32'h0000_0050, 32'h60);
    idle();
    // both masked, nothing else: no entry
    clear_in();
    req_fiq = 1; req_irq = 1; insn_done = 1;
    cur_status = 32'h0000_00D0;
    step();
    chk("R4 both masked no entry", 32'(entry_stb), 0);
    chk("R4 both masked no pc write", 32'(pc_we), 0);
    idle();
  endtask

  task automatic t_insn_wait();
    @(negedge clk);
    clear_in();
    req_dabt = 1; req_swi = 1; insn_done = 0;
    cur_status = 32'h10;
    step();
    chk("R8 held without insn_done", 32'(entry_stb), 0);
    @(negedge clk);
    insn_done = 1; next_pc = 32'h77C;
    step();
    check_entry("R8 taken at boundary", 1, 32'h10, 32'h77C);
    idle();
    clear_in();
    req_reset = 1; insn_done = 0; cur_status = 32'hF000_0030;
    step();
    check_entry("R8 reset mid-instruction", 0, 32'hF000_0030, 32'h0);
    idle();
  endtask

  task automatic t_return();
    @(negedge clk);
    clear_in();
    ret_req = 1; insn_done = 1;
    saved_status = 32'h6000_0030; ret_addr = 32'h2468;
    step();
    chk("R9 ret_stb", 32'(ret_stb), 1);
    chk("R9 cpsr_we", 32'(cpsr_we), 1);
    chk("R9 pc_we", 32'(pc_we), 1);
    chk("R9 status restored", cpsr_data, 32'h6000_0030);
    chk("R9 pc restored", pc_data, 32'h2468);
    chk("R9 no link write", 32'(lr_we), 0);
    chk("R9 no save write", 32'(spsr_we), 0);
    chk("R9 no entry", 32'(entry_stb), 0);
    @(negedge clk);
    insn_done = 0;
    step();
    chk("R9 return waits for insn_done", 32'(ret_stb), 0);
    @(negedge clk);
    insn_done = 1; req_undef = 1; cur_status = 32'h13; next_pc = 32'h88;
    step();
    check_entry("R9 exception beats return", 5, 32'h13, 32'h88);
    idle();
  endtask

  task automatic t_pulse();
    @(negedge clk);
    clear_in();
    req_swi = 1; insn_done = 1; cur_status = 32'h10;
    step();
    chk("R10 pulse high", 32'(entry_stb), 1);
    @(negedge clk);
    clear_in();
    step();
    chk("R10 pulse gone entry_stb", 32'(entry_stb), 0);
    chk("R10 pulse gone pc_we", 32'(pc_we), 0);
    chk("R10 pulse gone cpsr_we", 32'(cpsr_we), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_state();
    @(negedge clk);
    rst_n = 1;
    t_each_kind(32'hA000_0010);
    t_each_kind(32'h5000_0030);
    t_pair(0, 1);
    t_pair(1, 2);
    t_pair(2, 3);
    t_pair(3, 4);
    t_pair(4, 5);
    t_pair(5, 6);
    t_pair(1, 6);
    t_masks();
    t_insn_wait();
    t_return();
    t_pulse();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule